// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects 64 level-sensitive interrupt request lines and reduces them to a single priority level and vector number for a processor. Each source has an 8-bit priority byte. A nonzero byte turns the source on and a zero byte turns it off. A 64-bit mask can hold any source back. A 64-bit force register can raise a source from software, even when its request line is low. A source whose request or force bit is set, which is enabled and which is not masked, competes for the output.

The output pair is registered. The level is the winner's priority byte. The vector is the winner's index plus 64. When nothing competes, the level is 0 and the vector is 24.

Software uses a simple register bus with an 8-bit offset and 32-bit data. Through it, software reads the pending, mask and force registers as two 32-bit halves each, reads and writes the 64 priority bytes, and reads the current vector at a software acknowledge offset.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_level is 0 and irq_vector is 24. The mask reads all ones at 0x08 and 0x0C. Pending (0x00, 0x04), force (0x10, 0x14) and every priority byte read 0.
- R2: A source competes only while its request bit or force bit is 1, its priority byte is nonzero and its mask bit is 0. Setting the mask bit removes it from the output.
- R3: A write at offset 0x40+n stores bus_wdata[7:0] as the priority of source n, and a read there returns it zero-extended. Writing 0 disables source n, even while its request line is high.
- R4: Among competing sources, the one with the largest priority byte wins. irq_level equals that byte and irq_vector equals 64 plus its index.
- R5: When competing sources share the largest priority byte, the one with the higher index wins.
- R6: With no competing source, irq_level is 0 and irq_vector is 24.
- R7: Offset 0x00 reads pending bits 63:32 and offset 0x04 reads bits 31:0. Each pending bit equals its request line as sampled at the previous clock edge. Writes at 0x00 and 0x04 change nothing.
- R8: A write at 0x08 replaces mask bits 63:32 and a write at 0x0C replaces bits 31:0. The other half keeps its value.
- R9: A write at 0x10 loads force bits 63:32 and a write at 0x14 loads bits 31:0. Both halves read back at the same offsets. A forced source competes exactly like a requesting one.
- R10: A read at 0xE0 returns the current irq_vector, zero-extended. Reads at any other unmapped offset, including 0xE1 to 0xE7, return 0. Writes at unmapped offsets change nothing.
- R11: irq_level and irq_vector change on the second clock edge after a request line changes, and on the first edge after a register write. bus_rdata loads on the edge where bus_rd is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 64 | Level-sensitive request lines, bit n for source n |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_level | output | 8 | Winning priority, 0 when idle |
| irq_vector | output | 8 | Winning vector, 64 plus index, or 24 when idle |

## Verification
The bench drives every one of the 64 sources alone, checks its vector and level, and reads back its priority byte and pending bit. A swapped index or a misplaced half-word would show up here as a wrong vector or a bit in the wrong register word.

Adjacent pairs with equal priority are swept to catch a tie-break that favours the lower index. High-versus-low pairs across the two register halves are swept to catch a comparator that keeps the first winner it sees.

The bench also targets the enable rule, since a design that enables on a written byte rather than a nonzero one would keep a zeroed source alive. It checks that each mask half write leaves the other half alone and that pending writes are dropped. It checks the two-edge request latency and the spurious vector, which a design that forgot the idle case would report as 64.

// File: rtl/prio_irq_pkg.sv
// Package: prio_irq_pkg
// Shared register offsets and the offset decoder for the interrupt
// controller. Assumes an 8-bit byte offset on the register bus.
package prio_irq_pkg;

    localparam logic [7:0] OFF_PEND_HI  = 8'h00;
    localparam logic [7:0] OFF_PEND_LO  = 8'h04;
    localparam logic [7:0] OFF_MASK_HI  = 8'h08;
    localparam logic [7:0] OFF_MASK_LO  = 8'h0C;
    localparam logic [7:0] OFF_FRC_HI   = 8'h10;
    localparam logic [7:0] OFF_FRC_LO   = 8'h14;
    localparam logic [7:0] OFF_SWACK    = 8'hE0;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PEND_HI,
        SEL_PEND_LO,
        SEL_MASK_HI,
        SEL_MASK_LO,
        SEL_FRC_HI,
        SEL_FRC_LO,
        SEL_PRIO,
        SEL_SWACK
    } reg_sel_e;

    // Map a byte offset to the register it selects.
    function automatic reg_sel_e decode_sel(input logic [7:0] a);
        reg_sel_e s;
        if (a[7:6] == 2'b01) begin
            s = SEL_PRIO;
        end else begin
            case (a)
                OFF_PEND_HI: s = SEL_PEND_HI;
                OFF_PEND_LO: s = SEL_PEND_LO;
                OFF_MASK_HI: s = SEL_MASK_HI;
                OFF_MASK_LO: s = SEL_MASK_LO;
                OFF_FRC_HI:  s = SEL_FRC_HI;
                OFF_FRC_LO:  s = SEL_FRC_LO;
                OFF_SWACK:   s = SEL_SWACK;
                default:     s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/prio_irq_regs.sv
// Module: prio_irq_regs
// Holds the pending, mask, force and per-source priority state, and
// forms the per-source active vector. Assumes NUM_SRC is twice the
// bus data width, so each 64-bit register splits into two bus words.
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        irq_req,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [NUM_SRC-1:0]        pend_q,
    output logic [NUM_SRC-1:0]        mask_q,
    output logic [NUM_SRC-1:0]        force_q,
    output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic [NUM_SRC-1:0]        act_vec
);
    localparam int HALF  = NUM_SRC / 2;
    localparam int IDX_W = $clog2(NUM_SRC);

    reg_sel_e sel;
    assign sel = decode_sel(8'(addr));

    // Pending bits track the request lines one edge late.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= irq_req;
    end

    // Mask halves: each write replaces only the addressed half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_en && sel == SEL_MASK_HI) begin
            mask_q[NUM_SRC-1:HALF] <= wdata[HALF-1:0];
        end else if (wr_en && sel == SEL_MASK_LO) begin
            mask_q[HALF-1:0] <= wdata[HALF-1:0];
        end
    end

    // Force halves: software-raised interrupt bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_q <= '0;
        end else if (wr_en && sel == SEL_FRC_HI) begin
            force_q[NUM_SRC-1:HALF] <= wdata[HALF-1:0];
        end else if (wr_en && sel == SEL_FRC_LO) begin
            force_q[HALF-1:0] <= wdata[HALF-1:0];
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [PRIO_W-1:0] prio_r;
        logic              en_r;
        logic              hit;

        assign hit = wr_en && (sel == SEL_PRIO) &&
                     (addr[IDX_W-1:0] == IDX_W'(g));

        // Priority byte store; a nonzero byte enables the source.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_r <= '0;
                en_r   <= 1'b0;
            end else if (hit) begin
                prio_r <= wdata[PRIO_W-1:0];
                en_r   <= |wdata[PRIO_W-1:0];
            end
        end

        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_r;
        assign act_vec[g] = (pend_q[g] | force_q[g]) & en_r & ~mask_q[g];
    end

endmodule

// File: rtl/prio_irq_arb.sv
// Module: prio_irq_arb
// Combinational binary tournament over all sources. Each node keeps the
// higher priority, and on equal priority the higher index (right child).
// Assumes NUM_SRC is a power of two.
module prio_irq_arb #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        act_vec,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      win_vld,
    output logic [PRIO_W-1:0]         win_prio,
    output logic [IDX_W-1:0]          win_idx
);
    localparam int LVLS = IDX_W;

    logic              vld_t [LVLS+1][NUM_SRC];
    logic [PRIO_W-1:0] pri_t [LVLS+1][NUM_SRC];
    logic [IDX_W-1:0]  idx_t [LVLS+1][NUM_SRC];

    // Build the tree level by level, leaves first.
    always_comb begin
        for (int l = 0; l <= LVLS; l++) begin
            for (int k = 0; k < NUM_SRC; k++) begin
                vld_t[l][k] = 1'b0;
                pri_t[l][k] = '0;
                idx_t[l][k] = '0;
            end
        end
        for (int k = 0; k < NUM_SRC; k++) begin
            vld_t[0][k] = act_vec[k];
            pri_t[0][k] = prio_flat[k*PRIO_W +: PRIO_W];
            idx_t[0][k] = IDX_W'(k);
        end
        for (int l = 1; l <= LVLS; l++) begin
            for (int k = 0; k < (NUM_SRC >> l); k++) begin
                if (vld_t[l-1][2*k+1] &&
                    (!vld_t[l-1][2*k] ||
                     pri_t[l-1][2*k+1] >= pri_t[l-1][2*k])) begin
                    vld_t[l][k] = 1'b1;
                    pri_t[l][k] = pri_t[l-1][2*k+1];
                    idx_t[l][k] = idx_t[l-1][2*k+1];
                end else begin
                    vld_t[l][k] = vld_t[l-1][2*k];
                    pri_t[l][k] = pri_t[l-1][2*k];
                    idx_t[l][k] = idx_t[l-1][2*k];
                end
            end
        end
    end

    assign win_vld  = vld_t[LVLS][0];
    assign win_prio = pri_t[LVLS][0];
    assign win_idx  = idx_t[LVLS][0];

endmodule

// File: rtl/prio_irq_rdport.sv
// Module: prio_irq_rdport
// Register read multiplexer with a registered data output. Data loads
// on an edge with rd_en high and holds otherwise. Unmapped offsets read 0.
module prio_irq_rdport
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int VEC_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_SRC-1:0]        pend_q,
    input  logic [NUM_SRC-1:0]        mask_q,
    input  logic [NUM_SRC-1:0]        force_q,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [VEC_W-1:0]          vector,
    output logic [DATA_W-1:0]         rdata
);
    localparam int HALF  = NUM_SRC / 2;
    localparam int IDX_W = $clog2(NUM_SRC);

    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_nxt;
    logic [PRIO_W-1:0] byte_sel;

    assign sel      = decode_sel(8'(addr));
    assign byte_sel = prio_flat[addr[IDX_W-1:0]*PRIO_W +: PRIO_W];

    // Select the word addressed by the current offset.
    always_comb begin
        case (sel)
            SEL_PEND_HI: rd_nxt = DATA_W'(pend_q[NUM_SRC-1:HALF]);
            SEL_PEND_LO: rd_nxt = DATA_W'(pend_q[HALF-1:0]);
            SEL_MASK_HI: rd_nxt = DATA_W'(mask_q[NUM_SRC-1:HALF]);
            SEL_MASK_LO: rd_nxt = DATA_W'(mask_q[HALF-1:0]);
            SEL_FRC_HI:  rd_nxt = DATA_W'(force_q[NUM_SRC-1:HALF]);
            SEL_FRC_LO:  rd_nxt = DATA_W'(force_q[HALF-1:0]);
            SEL_PRIO:    rd_nxt = DATA_W'(byte_sel);
            SEL_SWACK:   rd_nxt = DATA_W'(vector);
            default:     rd_nxt = '0;
        endcase
    end

    // Capture read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_nxt;
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: prio_irq_ctrl
// Top of the interrupt controller. Registers the arbitration result
// into the level and vector outputs. The idle case reports level 0
// with the spurious vector. Assumes 64 sources and a 32-bit data bus.
module prio_irq_ctrl #(
    parameter int NUM_SRC  = 64,
    parameter int PRIO_W   = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int VEC_SPUR = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [PRIO_W-1:0]  irq_level,
    output logic [VEC_W-1:0]   irq_vector
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0]        pend_q;
    logic [NUM_SRC-1:0]        mask_q;
    logic [NUM_SRC-1:0]        force_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [NUM_SRC-1:0]        act_vec;
    logic                      win_vld;
    logic [PRIO_W-1:0]         win_prio;
    logic [IDX_W-1:0]          win_idx;

    prio_irq_regs #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .pend_q(pend_q), .mask_q(mask_q), .force_q(force_q),
        .prio_flat(prio_flat), .act_vec(act_vec)
    );

    prio_irq_arb #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)
    ) u_arb (
        .act_vec(act_vec), .prio_flat(prio_flat),
        .win_vld(win_vld), .win_prio(win_prio), .win_idx(win_idx)
    );

    prio_irq_rdport #(
        .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W),
        .ADDR_W(ADDR_W), .VEC_W(VEC_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .addr(bus_addr),
        .pend_q(pend_q), .mask_q(mask_q), .force_q(force_q),
        .prio_flat(prio_flat), .vector(irq_vector), .rdata(bus_rdata)
    );

    // Register the winner as level and vector, or the idle pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level  <= '0;
            irq_vector <= VEC_W'(VEC_SPUR);
        end else if (win_vld) begin
            irq_level  <= win_prio;
            irq_vector <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
        end else begin
            irq_level  <= '0;
            irq_vector <= VEC_W'(VEC_SPUR);
        end
    end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Module: prio_irq_ctrl_chk
// Property checker bound to prio_irq_ctrl. Keeps its own one-edge-late
// copies of the active set and priorities, and checks the registered
// outputs against a linear maximum over that copy.
module prio_irq_ctrl_chk #(
    parameter int NUM_SRC  = 64,
    parameter int PRIO_W   = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int VEC_SPUR = 24
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic                      bus_rd,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic [PRIO_W-1:0]         irq_level,
    input logic [VEC_W-1:0]          irq_vector,
    input logic [NUM_SRC-1:0]        act_vec,
    input logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input logic [NUM_SRC-1:0]        mask_q
);
    localparam int HALF  = NUM_SRC / 2;
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0]        act_d;
    logic [NUM_SRC*PRIO_W-1:0] prio_d;
    logic [PRIO_W-1:0]         max_d;
    logic [IDX_W-1:0]          vec_idx;

    // Delayed copies line up with the registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_d  <= '0;
            prio_d <= '0;
        end else begin
            act_d  <= act_vec;
            prio_d <= prio_flat;
        end
    end

    // Linear maximum over the delayed active set.
    always_comb begin
        max_d = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (act_d[i] && prio_d[i*PRIO_W +: PRIO_W] > max_d)
                max_d = prio_d[i*PRIO_W +: PRIO_W];
        end
    end

    assign vec_idx = IDX_W'(irq_vector - VEC_W'(VEC_BASE));

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (irq_level == '0 && irq_vector == VEC_W'(VEC_SPUR)));

    // R6
    idle_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level == '0 |-> irq_vector == VEC_W'(VEC_SPUR));

    // R2
    winner_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level != '0 |-> (irq_vector >= VEC_W'(VEC_BASE) && act_d[vec_idx]));

    // R4
    max_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level == max_d);

    // R10
    swack_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(8'hE0)) |=>
            bus_rdata == DATA_W'($past(irq_vector)));

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > ADDR_W'(8'hE0)) |=> bus_rdata == '0);

    // R8
    mask_lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(8'h08)) |=>
            mask_q[HALF-1:0] == $past(mask_q[HALF-1:0]));

    // R8
    mask_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(8'h0C)) |=>
            mask_q[NUM_SRC-1:HALF] == $past(mask_q[NUM_SRC-1:HALF]));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_SPUR(VEC_SPUR)
) u_chk (.*);

// File: tb/prio_irq_ctrl_tb.sv
// Bench: prio_irq_ctrl_tb
// Sweeps every source alone, adjacent ties and cross-half pairs, and
// computes the expected vector and level from the index and priority.
module prio_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_req = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_level;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic out_chk(input string tag, input int lvl, input int vec);
        chk({tag, " level"}, 32'(irq_level), 32'(lvl));
        chk({tag, " vector"}, 32'(irq_vector), 32'(vec));
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        out_chk("R1 reset", 0, 24);
        rd(8'h08, d); chk("R1 mask hi", d, 32'hFFFF_FFFF);
        rd(8'h0C, d); chk("R1 mask lo", d, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R1 pend hi", d, 0);
        rd(8'h14, d); chk("R1 force lo", d, 0);
        rd(8'h40, d); chk("R1 prio0", d, 0);
        rd(8'h7F, d); chk("R1 prio63", d, 0);

        // R8 mask halves are independent
        wr(8'h0C, 32'h1234_5678);
        rd(8'h08, d); chk("R8 hi kept", d, 32'hFFFF_FFFF);
        wr(8'h08, 32'h9ABC_DEF0);
        rd(8'h0C, d); chk("R8 lo kept", d, 32'h1234_5678);
        rd(8'h08, d); chk("R8 hi new", d, 32'h9ABC_DEF0);
        wr(8'h08, 0); wr(8'h0C, 0);

        // R6 all requests high, no priorities: still idle
        irq_req = '1; settle();
        out_chk("R6 no enable", 0, 24);
        irq_req = '0; settle();

        // R3 R4 R7 every source alone
        for (int n = 0; n < 64; n++) begin
            int p;
            p = (n % 15) + 1;
            wr(8'(8'h40 + n), 32'(p));
            irq_req[n] = 1'b1; settle();
            out_chk($sformatf("R4 src%0d", n), p, 64 + n);
            rd(8'(8'h40 + n), d); chk($sformatf("R3 rb%0d", n), d, 32'(p));
            rd(8'h00, d);
            chk($sformatf("R7 hi%0d", n), d, (n >= 32) ? (32'd1 << (n - 32)) : 0);
            rd(8'h04, d);
            chk($sformatf("R7 lo%0d", n), d, (n < 32) ? (32'd1 << n) : 0);
            irq_req[n] = 1'b0;
            wr(8'(8'h40 + n), 0); settle();
        end
        out_chk("R6 after sweep", 0, 24);

        // R3 zero byte disables a requesting source
        wr(8'h45, 3); irq_req[5] = 1'b1; settle();
        out_chk("R3 on", 3, 69);
        wr(8'h45, 0); settle();
        out_chk("R3 zero disables", 0, 24);
        irq_req[5] = 1'b0;

        // R2 mask removes a source
        wr(8'h4A, 4); irq_req[10] = 1'b1; settle();
        wr(8'h0C, 32'h0000_0400); settle();
        out_chk("R2 masked", 0, 24);
        wr(8'h0C, 0); settle();
        out_chk("R2 unmasked", 4, 74);
        irq_req[10] = 1'b0; wr(8'h4A, 0);

        // R4 higher priority wins across halves, both directions
        for (int n = 0; n < 32; n++) begin
            wr(8'(8'h40 + n), 9); wr(8'(8'h40 + n + 32), 3);
            irq_req[n] = 1'b1; irq_req[n+32] = 1'b1; settle();
            out_chk($sformatf("R4 low wins %0d", n), 9, 64 + n);
            wr(8'(8'h40 + n), 2); settle();
            out_chk($sformatf("R4 high wins %0d", n), 3, 96 + n);
            irq_req[n] = 1'b0; irq_req[n+32] = 1'b0;
            wr(8'(8'h40 + n), 0); wr(8'(8'h40 + n + 32), 0);
        end

        // R5 adjacent ties go to the higher index
        for (int n = 0; n < 63; n++) begin
            wr(8'(8'h40 + n), 5); wr(8'(8'h40 + n + 1), 5);
            irq_req[n] = 1'b1; irq_req[n+1] = 1'b1; settle();
            out_chk($sformatf("R5 tie %0d", n), 5, 65 + n);
            irq_req[n] = 1'b0; irq_req[n+1] = 1'b0;
            wr(8'(8'h40 + n), 0); wr(8'(8'h40 + n + 1), 0);
        end
        wr(8'h43, 7); wr(8'h68, 7); wr(8'h7C, 7);
        irq_req[3] = 1'b1; irq_req[40] = 1'b1; irq_req[60] = 1'b1; settle();
        out_chk("R5 three way", 7, 124);
        irq_req = '0; wr(8'h43, 0); wr(8'h68, 0); wr(8'h7C, 0); settle();

        // R9 force raises sources without requests
        wr(8'h43, 2); wr(8'h14, 32'h0000_0008); settle();
        out_chk("R9 force lo", 2, 67);
        wr(8'h68, 2); wr(8'h10, 32'h0000_0100); settle();
        out_chk("R9 force hi tie", 2, 104);
        rd(8'h10, d); chk("R9 rb hi", d, 32'h0000_0100);
        rd(8'h14, d); chk("R9 rb lo", d, 32'h0000_0008);
        rd(8'h00, d); chk("R9 pend untouched", d, 0);

        // R10 software acknowledge and unmapped reads
        rd(8'hE0, d); chk("R10 swack", d, 104);
        rd(8'hE3, d); chk("R10 E3", d, 0);
        rd(8'h20, d); chk("R10 0x20", d, 0);
        wr(8'h10, 0); wr(8'h14, 0); settle();
        rd(8'hE0, d); chk("R10 swack idle", d, 24);

        // R7 pending writes ignored; R10 unmapped writes ignored
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF); settle();
        out_chk("R7 pend write", 0, 24);
        rd(8'h04, d); chk("R7 pend lo after write", d, 0);
        wr(8'h30, 32'hFFFF_FFFF); wr(8'hE0, 32'hFFFF_FFFF); settle();
        rd(8'h0C, d); chk("R10 mask after bad write", d, 0);
        out_chk("R10 out after bad write", 0, 24);

        // R11 latency: two edges from request to output
        wr(8'h47, 5); settle();
        @(negedge clk); irq_req[7] = 1'b1;
        @(negedge clk);
        out_chk("R11 edge1", 0, 24);
        @(negedge clk);
        out_chk("R11 edge2", 5, 71);
        // R11 one edge from register write to output
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0000_0080;
        @(negedge clk); bus_wr = 1'b0;
        out_chk("R11 write edge1", 5, 71);
        @(negedge clk);
        out_chk("R11 write edge2", 0, 24);
        // R11 read data holds without a strobe
        rd(8'h0C, d);
        repeat (3) @(negedge clk);
        chk("R11 rdata hold", bus_rdata, 32'h0000_0080);

        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            report();
        end
    end

endmodule